// File: doc/BRIEF.md
# SIMD Address Coalescing Unit

This unit sits between a SIMD thread's load/store issue point and the memory interface. Each request it takes carries one byte address per lane and a mask that marks which lanes are active. Every lane access is treated as gather/scatter. No instruction says that the access is unit-stride, so the unit works out at runtime how the active lanes group into aligned 256-byte blocks of 32 eight-byte words. It then asks the memory interface for the smallest set of block transfers that covers every active lane.

The decision covers all lanes of one SIMD instruction at once. When the active lanes address consecutive words in lane order and stay inside one block, exactly one block request goes out, flagged as sequential. In any other case the unit sends one request for each distinct block touched, in ascending address order, at most one per cycle, whenever the memory side is ready. Each request carries:

- the block base address,
- the mask of the lanes it serves,
- each served lane's word offset inside the block.

No new instruction is taken until the last block request of the current one has been accepted.

The control is a two-state machine. In IDLE the input is ready. In EMIT the unit presents block requests. The transitions are:

- ACCEPT: IDLE to EMIT, when a request with at least one active lane is taken.
- DROP: IDLE to IDLE, when a request with an empty mask is taken.
- STALL: EMIT to EMIT, when the presented block is not accepted.
- NEXT: EMIT to EMIT, when a block that is not the last is accepted.
- DONE: EMIT to IDLE, when the last block is accepted.

Top module: `coal_unit`

## Requirements
- R1: After reset, req_ready is 1 and blk_valid is 0.
- R2: A lane byte address splits into a block base (the address with bits 7:0 cleared) and a word offset (bits 7:3). Bits 2:0 have no effect on any output.
- R3: For an accepted request, the unit emits exactly one block request per distinct block touched by the active lanes. blk_lanes has bit i set when lane i is active and falls in that block. Inactive lanes are ignored.
- R4: The block requests of one instruction are emitted in strictly ascending block base order.
- R5: blk_offs holds a 5-bit field per lane, lane i at bits 5i+4:5i. The field holds the lane's word offset when the lane is set in blk_lanes, and 0 otherwise.
- R6: blk_seq is 1 on every request of an instruction exactly when all of its active lanes lie in one block and lane i addresses word w0+(i-f), where f is the lowest active lane and w0 is its word address. Such an instruction produces exactly one request.
- R7: req_ready is 0 from the cycle after a request with a non-empty mask is accepted until the final block request is accepted. It is 1 in the cycle that follows.
- R8: A request with an all-zero mask produces no block request, and req_ready stays 1.
- R9: While blk_valid is 1 and blk_ready is 0, the presented request holds its values into the next cycle.
- R10: blk_last is 1 on the final block request of an instruction and 0 on the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lane request offered |
| req_ready | output | 1 | Lane request can be taken |
| req_addr | input | LANES*ADDR_W | Per-lane byte address, lane i at bits ADDR_W*i upward |
| req_mask | input | LANES | Per-lane active flag |
| blk_valid | output | 1 | Block request presented |
| blk_ready | input | 1 | Memory interface takes the block request |
| blk_addr | output | ADDR_W | Block base address, 256-byte aligned |
| blk_lanes | output | LANES | Lanes served by this block request |
| blk_offs | output | LANES*5 | Per-lane word offset within the block |
| blk_seq | output | 1 | Instruction was detected as unit-stride in one block |
| blk_last | output | 1 | Final block request of the instruction |

## Verification
Two functions can coincide:

- acceptance of the final block request by the memory side, and
- release of the input hold-off, with a waiting instruction at the input.

The bench holds req_valid high for the next instruction while it throttles blk_ready at random, so the final handshake often lands after several stalled cycles. It then checks three things. req_ready stays low through every presented block. It rises in exactly the cycle after the final handshake. It never overlaps blk_valid. Random mixes of unit-stride, block-straddling, scattered and reversed patterns confirm that the block count, the order, the masks and the offsets match a model built in the bench.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } coal_state_e;
endpackage

// File: rtl/coal_lane_split.sv
module coal_lane_split #(
    parameter int ADDR_W  = 32,
    parameter int WORD_LG = 3,
    parameter int BLK_LG  = 8,
    localparam int WORD_W = ADDR_W - WORD_LG,
    localparam int BLK_W  = ADDR_W - BLK_LG,
    localparam int OFF_W  = BLK_LG - WORD_LG
) (
    input  logic [WORD_W-1:0] word_addr,
    output logic [BLK_W-1:0]  blk_idx,
    output logic [OFF_W-1:0]  word_off
);
    assign blk_idx  = word_addr[WORD_W-1:OFF_W];
    assign word_off = word_addr[OFF_W-1:0];
endmodule

// File: rtl/coal_seq_detect.sv
module coal_seq_detect #(
    parameter int LANES  = 32,
    parameter int WORD_W = 29,
    parameter int BLK_W  = 24
) (
    input  logic [LANES-1:0]             mask,
    input  logic [LANES-1:0][WORD_W-1:0] words,
    input  logic [LANES-1:0][BLK_W-1:0]  blks,
    output logic                         is_seq
);
    always_comb begin
        int  first;
        logic seen;
        logic ok;
        first = 0;
        seen  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i] && !seen) begin
                first = i;
                seen  = 1'b1;
            end
        end
        ok = seen;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) begin
                if (blks[i] != blks[first]) ok = 1'b0;
                if (words[i] != words[first] + WORD_W'(i - first)) ok = 1'b0;
            end
        end
        is_seq = ok;
    end
endmodule

// File: rtl/coal_min_pick.sv
module coal_min_pick #(
    parameter int LANES = 32,
    parameter int BLK_W = 24
) (
    input  logic [LANES-1:0]            pend,
    input  logic [LANES-1:0][BLK_W-1:0] blks,
    output logic [BLK_W-1:0]            min_blk,
    output logic [LANES-1:0]            hit
);
    always_comb begin
        logic seen;
        seen    = 1'b0;
        min_blk = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pend[i] && (!seen || blks[i] < min_blk)) begin
                min_blk = blks[i];
                seen    = 1'b1;
            end
        end
        for (int i = 0; i < LANES; i++) begin
            hit[i] = pend[i] && (blks[i] == min_blk);
        end
    end
endmodule

// File: rtl/coal_unit.sv
module coal_unit
    import coal_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 32,
    parameter int WORD_LG = 3,
    parameter int BLK_LG  = 8,
    localparam int WORD_W = ADDR_W - WORD_LG,
    localparam int BLK_W  = ADDR_W - BLK_LG,
    localparam int OFF_W  = BLK_LG - WORD_LG
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    output logic                    blk_valid,
    input  logic                    blk_ready,
    output logic [ADDR_W-1:0]       blk_addr,
    output logic [LANES-1:0]        blk_lanes,
    output logic [LANES*OFF_W-1:0]  blk_offs,
    output logic                    blk_seq,
    output logic                    blk_last
);
    coal_state_e state_q, state_d;

    logic [LANES-1:0][WORD_W-1:0] word_q;
    logic [LANES-1:0][BLK_W-1:0]  blk_w;
    logic [LANES-1:0][OFF_W-1:0]  off_w;
    logic [LANES-1:0]             mask_q, pend_q, hit;
    logic [BLK_W-1:0]             min_blk;
    logic                         seq;
    logic [LANES*WORD_LG-1:0]     unused_low_bits;

    wire take_req = req_valid && (state_q == S_IDLE);
    wire take_blk = blk_ready && (state_q == S_EMIT);
    wire rest_empty = ((pend_q & ~hit) == '0);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign unused_low_bits[g*WORD_LG +: WORD_LG] = req_addr[g*ADDR_W +: WORD_LG];
            coal_lane_split #(
                .ADDR_W (ADDR_W),
                .WORD_LG(WORD_LG),
                .BLK_LG (BLK_LG)
            ) u_split (
                .word_addr(word_q[g]),
                .blk_idx  (blk_w[g]),
                .word_off (off_w[g])
            );
        end
    endgenerate

    coal_seq_detect #(
        .LANES (LANES),
        .WORD_W(WORD_W),
        .BLK_W (BLK_W)
    ) u_seq (
        .mask  (mask_q),
        .words (word_q),
        .blks  (blk_w),
        .is_seq(seq)
    );

    coal_min_pick #(
        .LANES(LANES),
        .BLK_W(BLK_W)
    ) u_pick (
        .pend   (pend_q),
        .blks   (blk_w),
        .min_blk(min_blk),
        .hit    (hit)
    );

    // Next state: ACCEPT, DROP, STALL, NEXT, DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (take_req && (req_mask != '0)) state_d = S_EMIT;
            S_EMIT: if (take_blk && rest_empty)       state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Instruction storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            mask_q <= '0;
            pend_q <= '0;
        end else if (take_req) begin
            for (int i = 0; i < LANES; i++) begin
                word_q[i] <= req_addr[i*ADDR_W+WORD_LG +: WORD_W];
            end
            mask_q <= req_mask;
            pend_q <= req_mask;
        end else if (take_blk) begin
            pend_q <= pend_q & ~hit;
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        blk_valid = 1'b0;
        unique case (state_q)
            S_IDLE: req_ready = 1'b1;
            S_EMIT: blk_valid = 1'b1;
            default: req_ready = 1'b0;
        endcase
        blk_addr  = {min_blk, {BLK_LG{1'b0}}};
        blk_lanes = hit;
        blk_seq   = seq;
        blk_last  = rest_empty;
        for (int i = 0; i < LANES; i++) begin
            blk_offs[i*OFF_W +: OFF_W] = hit[i] ? off_w[i] : '0;
        end
    end
endmodule

// File: rtl/coal_unit_chk.sv
module coal_unit_chk #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LANES-1:0]  req_mask,
    input logic              blk_valid,
    input logic              blk_ready,
    input logic [ADDR_W-1:0] blk_addr,
    input logic [LANES-1:0]  blk_lanes,
    input logic              blk_seq,
    input logic              blk_last
);
    // R7: input held off while block requests are presented
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && blk_valid));

    // R7: a non-empty request leads to block output next cycle
    assert_accept_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mask != '0)) |=> blk_valid);

    // R8: an empty mask leaves the input ready
    assert_empty_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mask == '0)) |=> (req_ready && !blk_valid));

    // R9: stalled request holds
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_addr) &&
                                       $stable(blk_lanes) && $stable(blk_last)));

    // R4: ascending block order within one instruction
    assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_ready && !blk_last) |=> (blk_valid && (blk_addr > $past(blk_addr))));

    // R3: every presented block serves at least one lane
    assert_lanes_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (blk_lanes != '0));

    // R6: a sequential instruction yields a single request
    assert_seq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_seq) |-> blk_last);

    // R10: final request accepted releases the input
    assert_last_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_ready && blk_last) |=> (req_ready && !blk_valid));
endmodule

bind coal_unit coal_unit_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/coal_unit_bench.sv
`timescale 1ns/100ps
module coal_unit_bench;
    localparam int LANES = 32;
    localparam int AW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES-1:0]    req_mask = '0;
    logic blk_valid;
    logic blk_ready = 1'b0;
    logic [AW-1:0]       blk_addr;
    logic [LANES-1:0]    blk_lanes;
    logic [LANES*5-1:0]  blk_offs;
    logic blk_seq, blk_last;

    coal_unit u_coal_unit (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0]      t_addr [LANES];
    logic [31:0]      t_mask;
    int               exp_n;
    logic [31:0]      exp_blk   [LANES];
    logic [31:0]      exp_lanes [LANES];
    logic             exp_seq;

    task automatic chk(input bit ok, input string tag, input logic [159:0] act,
                       input logic [159:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    // Bench model of the grouping, order and sequential rules (R3, R4, R6)
    task automatic model();
        logic [31:0] rem;
        logic [31:0] mn;
        bit seen;
        int first;
        rem = t_mask;
        exp_n = 0;
        while (rem != 0) begin
            seen = 0;
            mn = 0;
            for (int i = 0; i < LANES; i++)
                if (rem[i] && (!seen || (t_addr[i] >> 8) < mn)) begin
                    mn = t_addr[i] >> 8;
                    seen = 1;
                end
            exp_blk[exp_n] = mn << 8;
            exp_lanes[exp_n] = 0;
            for (int i = 0; i < LANES; i++)
                if (rem[i] && (t_addr[i] >> 8) == mn) exp_lanes[exp_n][i] = 1'b1;
            rem = rem & ~exp_lanes[exp_n];
            exp_n++;
        end
        exp_seq = (t_mask != 0) && (exp_n == 1);
        first = 0;
        for (int i = LANES - 1; i >= 0; i--) if (t_mask[i]) first = i;
        for (int i = 0; i < LANES; i++)
            if (t_mask[i] && ((t_addr[i] >> 3) != (t_addr[first] >> 3) + 32'(i - first)))
                exp_seq = 0;
    endtask

    task automatic run_case(input bit hold_next);
        logic [159:0] eoffs;
        logic [31:0] prev_addr;
        bit stalled;
        logic [31:0] st_addr;
        int k;
        model();
        @(negedge clk);
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = t_addr[i];
        req_mask = t_mask;
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R7 ready before accept", 160'(req_ready), 160'(1));
        @(posedge clk);
        @(negedge clk);
        req_valid = hold_next;
        if (exp_n == 0) begin
            chk(req_ready == 1'b1 && blk_valid == 1'b0, "R8 empty mask",
                160'({req_ready, blk_valid}), 160'(2'b10));
            req_valid = 1'b0;
            return;
        end
        k = 0;
        stalled = 0;
        prev_addr = 0;
        st_addr = 0;
        while (k < exp_n) begin
            blk_ready = ($urandom % 10) < 6;
            chk(blk_valid == 1'b1 && req_ready == 1'b0, "R7 hold-off while emitting",
                160'({blk_valid, req_ready}), 160'(2'b10));
            if (stalled)
                chk(blk_addr == st_addr, "R9 stall hold", 160'(blk_addr), 160'(st_addr));
            if (blk_ready) begin
                eoffs = 0;
                for (int i = 0; i < LANES; i++)
                    if (exp_lanes[k][i]) eoffs[i*5 +: 5] = t_addr[i][7:3];
                chk(blk_addr == exp_blk[k], "R2 block base", 160'(blk_addr), 160'(exp_blk[k]));
                chk(blk_lanes == exp_lanes[k], "R3 lane mask", 160'(blk_lanes), 160'(exp_lanes[k]));
                chk(blk_offs == eoffs, "R5 word offsets", 160'(blk_offs), eoffs);
                chk(blk_seq == exp_seq, "R6 sequential flag", 160'(blk_seq), 160'(exp_seq));
                chk(blk_last == (k == exp_n - 1), "R10 last flag", 160'(blk_last),
                    160'(k == exp_n - 1));
                if (k > 0)
                    chk(blk_addr > prev_addr, "R4 ascending", 160'(blk_addr), 160'(prev_addr));
                prev_addr = blk_addr;
                k++;
                stalled = 0;
            end else begin
                stalled = 1;
                st_addr = blk_addr;
            end
            @(posedge clk);
            @(negedge clk);
        end
        blk_ready = 1'b0;
        chk(req_ready == 1'b1 && blk_valid == 1'b0, "R3 request count and R7 release",
            160'({req_ready, blk_valid}), 160'(2'b10));
        req_valid = 1'b0;
    endtask

    task automatic gen(input int mode);
        logic [31:0] base;
        base = $urandom & 32'h7FFF_FF00;
        t_mask = $urandom;
        case (mode)
            0: begin
                for (int i = 0; i < LANES; i++) t_addr[i] = base + 32'(i * 8);
                t_mask = '1;
            end
            1: for (int i = 0; i < LANES; i++)
                   t_addr[i] = base + 32'((1 + $urandom % 31) * 8) + 32'(i * 8);
            2: for (int i = 0; i < LANES; i++)
                   t_addr[i] = base + 32'(($urandom % 3) * 256) + ($urandom & 32'hFF);
            3: for (int i = 0; i < LANES; i++) t_addr[i] = base + 32'(i * 8);
            4: begin
                for (int i = 0; i < LANES; i++) t_addr[i] = $urandom;
                t_mask = $urandom & $urandom;
            end
            default: for (int i = 0; i < LANES; i++) t_addr[i] = base + 32'((31 - i) * 8);
        endcase
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && blk_valid == 1'b0, "R1 reset state",
            160'({req_ready, blk_valid}), 160'(2'b10));
        rst_n = 1'b1;

        // Directed: empty mask (R8)
        gen(0); t_mask = 0; run_case(0);
        // Directed: full unit-stride block (R6)
        gen(0); run_case(1);
        // Directed: single top lane with junk low bits (R2)
        gen(3); t_mask = 32'h8000_0000; t_addr[31] = t_addr[31] | 32'h7; run_case(0);
        // Directed: reversed order in one block (R6 flag low, one request)
        gen(5); t_mask = '1; run_case(0);
        // Directed: all lanes on one address
        gen(0); for (int i = 1; i < LANES; i++) t_addr[i] = t_addr[0]; run_case(1);
        // Directed: straddling two blocks (R4)
        gen(1); t_mask = '1; run_case(0);

        for (int n = 0; n < 400; n++) begin
            gen(int'($urandom % 6));
            run_case(bit'($urandom % 2));
        end
        finish_run();
    end
endmodule